// File: doc/BRIEF.md
# Transfer Unit Configuration Solver

This block works out the packing settings for a DisplayPort stream once per mode set. It takes the pixel clock in kHz, the bits per pixel, the active lane count and a link rate code. It returns the transfer-unit (TU) size and the valid-symbol encoding that best fits the pixel data rate. The encoding has three parts: an integer count, a fractional divisor and an add/subtract flag. The block also returns a FIFO watermark value.

All arithmetic runs in fixed point, with one symbol scaled to 100000. Every product goes through a shared shift-add multiplier and every quotient through a shared restoring divider. Both units resolve one bit per cycle. A run starts with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. When no configuration can be produced, `fail` is raised instead.

Top module: `dptu_calc`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low, and `tu_size`, `vtu_int`, `vtu_frac`, `vtu_add` and `watermark` are all zero.
- R2: The ratio is computed as follows. Let bw = rate_code*27000. Let p = floor(floor(pclk_khz*bpp/8)/lanes). Then ratio = floor(p*100000/bw). TU sizes are tried from 64 down to 32. For each size T, the valid count is ratio*T, with integer part q and remainder d in units of 1/100000. A candidate replaces the best one only when its error is strictly smaller, so ties keep the larger TU. The starting best error is 64*100000. `tu_size` is a 7-bit unsigned value between 32 and 64.
- R3: When d >= 50000, the divisor is f = ceil(100000/(100000-d)). If f <= 15, then `vtu_add`=1 (1 means add), `vtu_frac`=f and the error is (100000-floor(100000/f))-d. If f > 15, then `vtu_add`=0, `vtu_frac`=1 and the error is 100000-d. When the add flag is set, the divisor is at least 2.
- R4: When 0 < d < 50000, `vtu_add`=0, `vtu_frac`=min(floor(100000/d),15) (a 4-bit field) and the error is floor(100000/vtu_frac)-d.
- R5: When d = 0, the candidate's integer part is q-1, its divisor is 1, its flag is 0 and its error is 0. The search stops as soon as a candidate with zero error is accepted. `vtu_frac` is never zero in a successful result.
- R6: `watermark` = floor((100000-ratio)*tu_size*ratio/10^10)+6. The 32-bit output is truncated from the 64-bit value.
- R7: `fail` is raised in three cases: `lanes` is 0, `rate_code` is 0, or no candidate is accepted. A candidate with d = 0 and q = 0 is rejected. While `fail` is high, all configuration outputs are zero. A later successful run clears `fail`.
- R8: `busy` rises the cycle after an accepted start. `done` is high for exactly one cycle, together with the new results, and `busy` is already low in that cycle.
- R9: A `start` while busy is ignored, including any new operands. The result outputs and `fail` change only in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request that latches the operands |
| pclk_khz | input | 32 | Pixel clock in kHz |
| bpp | input | 8 | Bits per pixel |
| lanes | input | 3 | Active lane count |
| rate_code | input | 8 | Link rate code, in units of 27000 kB/s |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No configuration found |
| tu_size | output | 7 | Chosen TU size |
| vtu_int | output | 7 | Integer part of the valid-symbol count |
| vtu_frac | output | 4 | Fractional divisor |
| vtu_add | output | 1 | 1 = add the fraction, 0 = subtract it |
| watermark | output | 32 | FIFO watermark |

## Verification
The bench builds the block with its default parameters: a TU span of 64 to 32, a divisor cap of 15 and a 64-bit datapath. With these, hand-computed modes can land on each encoding branch. One mode hits a zero remainder and stops at the first size. One mode hits an exact add-flag fit at size 60. A small-ratio mode hits an exact subtract fit at size 64. A zero pixel clock rejects every size in the span.

Realistic modes are compared with a reference model that walks the whole span. Those runs exercise the strict-improvement rule and the divisor cap.

// File: rtl/dptu_pkg.sv
// Package: shared state encoding for the TU solver.
// Assumes: one solver FSM per instance; the states follow the order of the computation.
package dptu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LINK,   // link bandwidth product
        ST_PIX,    // pixel clock times bits per pixel
        ST_LANE,   // split across lanes
        ST_SCALE,  // scale by one symbol
        ST_RATIO,  // divide by link bandwidth
        ST_TUV,    // valid count for current TU size
        ST_VI,     // integer part and remainder
        ST_RECIP,  // reciprocal divisor
        ST_FRAC,   // symbol share of the divisor
        ST_CMP,    // compare against best
        ST_WM_A,   // watermark first product
        ST_WM_B,   // watermark second product
        ST_WM_C,   // watermark division
        ST_FIN     // publish results
    } dptu_state_e;

endpackage

// File: rtl/dptu_mul.sv
// Module: iterative shift-add multiplier.
// Takes one multiplier bit per cycle (BW cycles per product).
// Assumes: go is only pulsed while idle; the product is truncated to AW bits.
module dptu_mul #(
    parameter int AW = 64,
    parameter int BW = 32,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [AW-1:0] prod,
    output logic          done
);

    logic [AW-1:0] acc;
    logic [AW-1:0] a_r;
    logic [BW-1:0] b_r;
    logic [CW-1:0] cnt;

    // Accumulate shifted partial products, one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            a_r  <= '0;
            b_r  <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc <= '0;
                a_r <= a;
                b_r <= b;
                cnt <= CW'(BW);
            end else if (cnt != '0) begin
                if (b_r[0]) acc <= acc + a_r;
                a_r <= a_r << 1;
                b_r <= b_r >> 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign prod = acc;

endmodule

// File: rtl/dptu_div.sv
// Module: restoring divider.
// Resolves one quotient bit per cycle (W cycles per quotient).
// Assumes: go is only pulsed while idle; a zero divisor gives an all-ones quotient.
module dptu_div #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         done
);

    logic [W:0]    part;
    logic [W-1:0]  q_r;
    logic [W-1:0]  d_r;
    logic [CW-1:0] cnt;
    logic [W:0]    shifted;
    logic [W+1:0]  trial;

    // Form the shifted partial remainder and the trial subtraction.
    always_comb begin
        shifted = {part[W-1:0], q_r[W-1]};
        trial   = {1'b0, shifted} - {2'b00, d_r};
    end

    // Keep or restore the partial remainder, shifting in quotient bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= '0;
            q_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                part <= '0;
                q_r  <= num;
                d_r  <= den;
                cnt  <= CW'(W);
            end else if (cnt != '0) begin
                if (!trial[W+1]) begin
                    part <= trial[W:0];
                    q_r  <= {q_r[W-2:0], 1'b1};
                end else begin
                    part <= shifted;
                    q_r  <= {q_r[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign quo = q_r;
    assign rem = part[W-1:0];

endmodule

// File: rtl/dptu_calc.sv
// Module: TU configuration solver (top).
// Derives the packed-data-to-link ratio, then searches TU sizes from large to small
// for the best valid-symbol encoding, then computes the FIFO watermark.
// Assumes: operands are latched on an accepted start; one shared multiplier and one
// shared divider, never active at the same time.
module dptu_calc
    import dptu_pkg::*;
#(
    parameter int KHZ_W      = 32,
    parameter int BPP_W      = 8,
    parameter int LANE_W     = 3,
    parameter int RATE_W     = 8,
    parameter int WM_W       = 32,
    parameter int SYM        = 100000,
    parameter int LINK_UNIT  = 27000,
    parameter int TU_MAX     = 64,
    parameter int TU_MIN     = 32,
    parameter int FRAC_MAX   = 15,
    parameter int WM_BIAS    = 6,
    parameter int BYTE_SHIFT = 3,
    parameter int DW         = 64,
    parameter int MB         = 32,
    localparam int TU_W      = $clog2(TU_MAX + 1),
    localparam int FRAC_W    = $clog2(FRAC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KHZ_W-1:0]  pclk_khz,
    input  logic [BPP_W-1:0]  bpp,
    input  logic [LANE_W-1:0] lanes,
    input  logic [RATE_W-1:0] rate_code,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [TU_W-1:0]   tu_size,
    output logic [TU_W-1:0]   vtu_int,
    output logic [FRAC_W-1:0] vtu_frac,
    output logic              vtu_add,
    output logic [WM_W-1:0]   watermark
);

    localparam logic [DW-1:0]     SYM_D      = DW'(SYM);
    localparam logic [DW-1:0]     HALF_D     = DW'(SYM / 2);
    localparam logic [DW-1:0]     SYM_SQ_D   = SYM_D * SYM_D;
    localparam logic [DW-1:0]     BEST_INIT  = DW'(TU_MAX) * SYM_D;
    localparam logic [DW-1:0]     FRAC_MAX_D = DW'(FRAC_MAX);
    localparam logic [DW-1:0]     BIAS_D     = DW'(WM_BIAS);
    localparam logic [TU_W-1:0]   TU_MAX_T   = TU_W'(TU_MAX);
    localparam logic [TU_W-1:0]   TU_MIN_T   = TU_W'(TU_MIN);
    localparam logic [MB-1:0]     SYM_B      = MB'(SYM);
    localparam logic [MB-1:0]     LINK_B     = MB'(LINK_UNIT);
    localparam logic [FRAC_W-1:0] FRAC_ONE   = FRAC_W'(1);

    dptu_state_e state;
    logic        pend;

    logic [KHZ_W-1:0]  khz_r;
    logic [BPP_W-1:0]  bpp_r;
    logic [LANE_W-1:0] lanes_r;
    logic [RATE_W-1:0] rate_r;

    logic [DW-1:0] link_r, work_r, ratio_r, diff_r, cur_vi, cur_err, best_err;
    logic          hi_r, cur_ok, cur_add, fail_r;
    logic [FRAC_W-1:0] cur_vf;
    logic [TU_W-1:0]   tu_r, best_tu, best_vi;
    logic [FRAC_W-1:0] best_vf;
    logic              best_add;

    logic          mul_go, div_go, mul_done, div_done, op_fin;
    logic [DW-1:0] mul_a, mul_prod, div_n, div_d, div_quo, div_rem;
    logic [MB-1:0] mul_b;
    logic [DW-1:0] recip_up;
    logic          accept;

    dptu_mul #(.AW(DW), .BW(MB)) mul_i (
        .clk(clk), .rst_n(rst_n), .go(mul_go), .a(mul_a), .b(mul_b),
        .prod(mul_prod), .done(mul_done)
    );

    dptu_div #(.W(DW)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_n), .den(div_d),
        .quo(div_quo), .rem(div_rem), .done(div_done)
    );

    // Choose the arithmetic operands for the current step and launch the unit once.
    always_comb begin
        mul_a  = '0;
        mul_b  = '0;
        div_n  = '0;
        div_d  = '0;
        mul_go = 1'b0;
        div_go = 1'b0;
        case (state)
            ST_LINK:  begin mul_a = DW'(rate_r);           mul_b = LINK_B;         mul_go = !pend; end
            ST_PIX:   begin mul_a = DW'(khz_r);            mul_b = MB'(bpp_r);     mul_go = !pend; end
            ST_SCALE: begin mul_a = work_r;                mul_b = SYM_B;          mul_go = !pend; end
            ST_TUV:   begin mul_a = ratio_r;               mul_b = MB'(tu_r);      mul_go = !pend; end
            ST_WM_A:  begin mul_a = SYM_D - ratio_r;       mul_b = MB'(best_tu);   mul_go = !pend; end
            ST_WM_B:  begin mul_a = work_r;                mul_b = ratio_r[MB-1:0]; mul_go = !pend; end
            ST_LANE:  begin div_n = work_r >> BYTE_SHIFT;  div_d = DW'(lanes_r);   div_go = !pend; end
            ST_RATIO: begin div_n = work_r;                div_d = link_r;         div_go = !pend; end
            ST_VI:    begin div_n = work_r;                div_d = SYM_D;          div_go = !pend; end
            ST_RECIP: begin div_n = SYM_D;  div_d = hi_r ? (SYM_D - diff_r) : diff_r; div_go = !pend; end
            ST_FRAC:  begin div_n = SYM_D;                 div_d = DW'(cur_vf);    div_go = !pend; end
            ST_WM_C:  begin div_n = work_r;                div_d = SYM_SQ_D;       div_go = !pend; end
            default:  ;
        endcase
    end

    // Round-up reciprocal, step completion and candidate acceptance.
    always_comb begin
        recip_up = div_quo + DW'(div_rem != '0);
        op_fin   = pend && (mul_done || div_done);
        accept   = cur_ok && (cur_err < best_err);
    end

    // Sequence the solver steps and hold the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= 1'b0;
            khz_r    <= '0;
            bpp_r    <= '0;
            lanes_r  <= '0;
            rate_r   <= '0;
            link_r   <= '0;
            work_r   <= '0;
            ratio_r  <= '0;
            diff_r   <= '0;
            hi_r     <= 1'b0;
            cur_ok   <= 1'b0;
            cur_vi   <= '0;
            cur_vf   <= '0;
            cur_add  <= 1'b0;
            cur_err  <= '0;
            best_err <= '0;
            best_tu  <= '0;
            best_vi  <= '0;
            best_vf  <= '0;
            best_add <= 1'b0;
            tu_r     <= '0;
            fail_r   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            tu_size  <= '0;
            vtu_int  <= '0;
            vtu_frac <= '0;
            vtu_add  <= 1'b0;
            watermark <= '0;
        end else begin
            done <= 1'b0;
            if (mul_go || div_go) pend <= 1'b1;
            if (op_fin) pend <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    khz_r    <= pclk_khz;
                    bpp_r    <= bpp;
                    lanes_r  <= lanes;
                    rate_r   <= rate_code;
                    best_err <= BEST_INIT;
                    best_tu  <= '0;
                    best_vi  <= '0;
                    best_vf  <= '0;
                    best_add <= 1'b0;
                    tu_r     <= TU_MAX_T;
                    fail_r   <= (lanes == '0) || (rate_code == '0);
                    state    <= ((lanes == '0) || (rate_code == '0)) ? ST_FIN : ST_LINK;
                end
                ST_LINK:  if (op_fin) begin link_r  <= mul_prod; state <= ST_PIX;   end
                ST_PIX:   if (op_fin) begin work_r  <= mul_prod; state <= ST_LANE;  end
                ST_LANE:  if (op_fin) begin work_r  <= div_quo;  state <= ST_SCALE; end
                ST_SCALE: if (op_fin) begin work_r  <= mul_prod; state <= ST_RATIO; end
                ST_RATIO: if (op_fin) begin ratio_r <= div_quo;  state <= ST_TUV;   end
                ST_TUV:   if (op_fin) begin work_r  <= mul_prod; state <= ST_VI;    end
                ST_VI: if (op_fin) begin
                    if (div_rem == '0) begin
                        cur_ok  <= (div_quo != '0);
                        cur_vi  <= div_quo - 1'b1;
                        cur_vf  <= FRAC_ONE;
                        cur_add <= 1'b0;
                        cur_err <= '0;
                        state   <= ST_CMP;
                    end else begin
                        cur_ok  <= 1'b1;
                        cur_vi  <= div_quo;
                        diff_r  <= div_rem;
                        hi_r    <= (div_rem >= HALF_D);
                        state   <= ST_RECIP;
                    end
                end
                ST_RECIP: if (op_fin) begin
                    if (hi_r && (recip_up <= FRAC_MAX_D)) begin
                        cur_vf  <= FRAC_W'(recip_up);
                        cur_add <= 1'b1;
                        state   <= ST_FRAC;
                    end else if (hi_r) begin
                        cur_vf  <= FRAC_ONE;
                        cur_add <= 1'b0;
                        cur_err <= SYM_D - diff_r;
                        state   <= ST_CMP;
                    end else begin
                        cur_vf  <= (div_quo > FRAC_MAX_D) ? FRAC_W'(FRAC_MAX) : FRAC_W'(div_quo);
                        cur_add <= 1'b0;
                        state   <= ST_FRAC;
                    end
                end
                ST_FRAC: if (op_fin) begin
                    cur_err <= (cur_add ? (SYM_D - div_quo) : div_quo) - diff_r;
                    state   <= ST_CMP;
                end
                ST_CMP: begin
                    if (accept) begin
                        best_err <= cur_err;
                        best_tu  <= tu_r;
                        best_vi  <= TU_W'(cur_vi);
                        best_vf  <= cur_vf;
                        best_add <= cur_add;
                    end
                    if ((accept && (cur_err == '0)) || (tu_r == TU_MIN_T)) begin
                        if (accept || (best_tu != '0)) begin
                            state <= ST_WM_A;
                        end else begin
                            fail_r <= 1'b1;
                            state  <= ST_FIN;
                        end
                    end else begin
                        tu_r  <= tu_r - 1'b1;
                        state <= ST_TUV;
                    end
                end
                ST_WM_A: if (op_fin) begin work_r <= mul_prod; state <= ST_WM_B; end
                ST_WM_B: if (op_fin) begin work_r <= mul_prod; state <= ST_WM_C; end
                ST_WM_C: if (op_fin) begin work_r <= div_quo + BIAS_D; state <= ST_FIN; end
                ST_FIN: begin
                    done      <= 1'b1;
                    fail      <= fail_r;
                    tu_size   <= fail_r ? '0 : best_tu;
                    vtu_int   <= fail_r ? '0 : best_vi;
                    vtu_frac  <= fail_r ? '0 : best_vf;
                    vtu_add   <= fail_r ? 1'b0 : best_add;
                    watermark <= fail_r ? '0 : WM_W'(work_r);
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dptu_calc_chk.sv
// Module: property checker for the TU solver, bound to the top.
// Assumes: it observes only the top-level ports.
module dptu_calc_chk #(
    parameter int TU_W   = 7,
    parameter int FRAC_W = 4,
    parameter int WM_W   = 32,
    parameter int TU_MIN = 32,
    parameter int TU_MAX = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [TU_W-1:0]   tu_size,
    input logic [TU_W-1:0]   vtu_int,
    input logic [FRAC_W-1:0] vtu_frac,
    input logic              vtu_add,
    input logic [WM_W-1:0]   watermark
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(tu_size) && $stable(vtu_int) && $stable(vtu_frac)
                   && $stable(vtu_add) && $stable(watermark) && $stable(fail)));

    // R7
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (tu_size == '0 && vtu_int == '0 && vtu_frac == '0 && !vtu_add && watermark == '0));

    // R2
    tu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (tu_size >= TU_W'(TU_MIN) && tu_size <= TU_W'(TU_MAX)));

    // R3
    add_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && vtu_add) |-> (vtu_frac >= FRAC_W'(2)));

    // R5
    frac_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (vtu_frac != '0));

endmodule

bind dptu_calc dptu_calc_chk #(
    .TU_W(TU_W), .FRAC_W(FRAC_W), .WM_W(WM_W), .TU_MIN(TU_MIN), .TU_MAX(TU_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .tu_size(tu_size), .vtu_int(vtu_int), .vtu_frac(vtu_frac), .vtu_add(vtu_add),
    .watermark(watermark)
);

// File: tb/dptu_calc_tb_top.sv
// Bench: directed scenarios for the TU solver, each task checking its own results.
`timescale 1ns/1ps
module dptu_calc_tb_top;

    localparam int RUN_LIMIT = 20000;
    localparam longint unsigned S = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pclk_khz = '0;
    logic [7:0]  bpp = '0;
    logic [2:0]  lanes = '0;
    logic [7:0]  rate_code = '0;
    logic        busy, done, fail, vtu_add;
    logic [6:0]  tu_size, vtu_int;
    logic [3:0]  vtu_frac;
    logic [31:0] watermark;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dptu_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz), .bpp(bpp),
        .lanes(lanes), .rate_code(rate_code), .busy(busy), .done(done), .fail(fail),
        .tu_size(tu_size), .vtu_int(vtu_int), .vtu_frac(vtu_frac), .vtu_add(vtu_add),
        .watermark(watermark)
    );

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent model of the requirements.
    function automatic void ref_calc(input longint unsigned khz, input longint unsigned bp,
                                     input longint unsigned ln, input longint unsigned rt,
                                     output logic f, output longint unsigned tu,
                                     output longint unsigned vi, output longint unsigned vf,
                                     output logic ad, output longint unsigned wm);
        longint unsigned link, ldr, ratio, tv, q, d, cf, gain, err, best;
        logic ok, cad;
        f = 1'b0; tu = 0; vi = 0; vf = 0; ad = 1'b0; wm = 0;
        if (ln == 0 || rt == 0) begin f = 1'b1; return; end
        link  = rt * 27000;
        ldr   = ((khz * bp) / 8) / ln;
        ratio = (ldr * S) / link;
        best  = 64 * S;
        for (int t = 64; t >= 32; t--) begin
            tv = ratio * longint'(t); q = tv / S; d = tv % S; ok = 1'b1; cad = 1'b0;
            if (d == 0) begin
                if (q == 0) ok = 1'b0;
                q = q - 1; cf = 1; err = 0;
            end else if (d >= S / 2) begin
                cf = S / (S - d);
                if (S % (S - d) != 0) cf++;
                if (cf <= 15) begin cad = 1'b1; gain = S - S / cf; end
                else begin cf = 1; gain = S; end
                err = gain - d;
            end else begin
                cf = S / d;
                if (cf > 15) cf = 15;
                gain = S / cf; err = gain - d;
            end
            if (ok && err < best) begin
                best = err; tu = longint'(t); vi = q; vf = cf; ad = cad;
                if (err == 0) break;
            end
        end
        if (tu == 0) begin f = 1'b1; vi = 0; vf = 0; ad = 1'b0; return; end
        wm = ((((S - ratio) * tu) * ratio) / (S * S) + 6) & 64'hFFFF_FFFF;
    endfunction

    // Pulse start with operands and wait for done; returns cycles taken.
    task automatic run(input int khz, input int bp, input int ln, input int rt, output int cyc);
        @(negedge clk);
        pclk_khz = 32'(khz); bpp = 8'(bp); lanes = 3'(ln); rate_code = 8'(rt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog: actual no done expected done within %0d", RUN_LIMIT);
        end
    endtask

    task automatic cmp_model(input int khz, input int bp, input int ln, input int rt,
                             input string tag);
        logic ef, ea; longint unsigned et, ev, efr, ew;
        ref_calc(khz, bp, ln, rt, ef, et, ev, efr, ea, ew);
        check("R7", {tag, " fail"}, 64'(fail), 64'(ef));
        check("R2", {tag, " tu_size"}, 64'(tu_size), et);
        check("R3", {tag, " vtu_int"}, 64'(vtu_int), ev);
        check("R4", {tag, " vtu_frac"}, 64'(vtu_frac), efr);
        check("R3", {tag, " vtu_add"}, 64'(vtu_add), 64'(ea));
        check("R6", {tag, " watermark"}, 64'(watermark), ew);
    endtask

    task automatic t_reset();
        check("R1", "busy", 64'(busy), 0);
        check("R1", "done", 64'(done), 0);
        check("R1", "fail", 64'(fail), 0);
        check("R1", "results", {tu_size, vtu_int, vtu_frac, vtu_add, watermark} , 0);
    endtask

    task automatic t_zero_rem();
        int c;
        run(180000, 24, 4, 10, c);
        check("R5", "tu_size", 64'(tu_size), 64);
        check("R5", "vtu_int", 64'(vtu_int), 31);
        check("R5", "vtu_frac", 64'(vtu_frac), 1);
        check("R5", "vtu_add", 64'(vtu_add), 0);
        check("R6", "watermark", 64'(watermark), 22);
        check("R5", "early stop cycles<1000", 64'(c < 1000), 1);
    endtask

    task automatic t_high_rem();
        int c;
        run(148500, 24, 4, 10, c);
        check("R3", "tu_size", 64'(tu_size), 60);
        check("R3", "vtu_int", 64'(vtu_int), 24);
        check("R3", "vtu_frac", 64'(vtu_frac), 4);
        check("R3", "vtu_add", 64'(vtu_add), 1);
        check("R6", "watermark", 64'(watermark), 20);
    endtask

    task automatic t_low_rem();
        int c;
        run(1350, 24, 1, 8, c);
        check("R4", "tu_size", 64'(tu_size), 64);
        check("R4", "vtu_int", 64'(vtu_int), 1);
        check("R4", "vtu_frac", 64'(vtu_frac), 5);
        check("R4", "vtu_add", 64'(vtu_add), 0);
        check("R6", "watermark", 64'(watermark), 7);
    endtask

    task automatic t_sweep();
        int c;
        run(148500, 24, 4, 6, c);   cmp_model(148500, 24, 4, 6, "m1");
        run(25175, 18, 1, 6, c);    cmp_model(25175, 18, 1, 6, "m2");
        run(594000, 30, 4, 20, c);  cmp_model(594000, 30, 4, 20, "m3");
        run(74250, 24, 2, 6, c);    cmp_model(74250, 24, 2, 6, "m4");
        run(108000, 24, 2, 10, c);  cmp_model(108000, 24, 2, 10, "m5");
    endtask

    task automatic t_fail();
        int c;
        run(148500, 24, 0, 10, c);
        check("R7", "fail lanes=0", 64'(fail), 1);
        check("R7", "tu_size on fail", 64'(tu_size), 0);
        run(148500, 24, 4, 0, c);
        check("R7", "fail rate=0", 64'(fail), 1);
        run(0, 24, 4, 10, c);
        check("R7", "fail khz=0", 64'(fail), 1);
        check("R7", "watermark on fail", 64'(watermark), 0);
        run(148500, 24, 4, 10, c);
        check("R7", "fail cleared", 64'(fail), 0);
        check("R7", "tu after clear", 64'(tu_size), 60);
    endtask

    task automatic t_handshake();
        int c;
        run(180000, 24, 4, 10, c);
        check("R8", "busy low at done", 64'(busy), 0);
        @(negedge clk);
        check("R8", "done one cycle", 64'(done), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", 64'(busy), 1);
        while (!done) @(negedge clk);
    endtask

    task automatic t_busy_start();
        int c;
        @(negedge clk);
        pclk_khz = 32'd148500; bpp = 8'd24; lanes = 3'd4; rate_code = 8'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        pclk_khz = 32'd1350; lanes = 3'd1; rate_code = 8'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < RUN_LIMIT) begin @(negedge clk); c++; end
        check("R9", "tu ignores busy start", 64'(tu_size), 60);
        check("R9", "vtu_frac ignores busy start", 64'(vtu_frac), 4);
        repeat (40) @(negedge clk);
        pclk_khz = 32'd0;
        repeat (5) @(negedge clk);
        check("R9", "held tu_size", 64'(tu_size), 60);
        check("R9", "held watermark", 64'(watermark), 20);
        check("R9", "held fail", 64'(fail), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_rem();
        t_high_rem();
        t_low_rem();
        t_sweep();
        t_fail();
        t_handshake();
        t_busy_start();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++; n_bad++;
        $display("FAIL R8 global watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule